// File: doc/BRIEF.md
# Master-Mode Stereo Serial Audio Transmitter

This block runs entirely from one master clock and produces the three serial-audio timing outputs itself: a bit clock, a left/right frame clock and a word-framing strobe. It shifts one 16-bit two's-complement left sample and one right sample out per 64-bit frame on a single data line, most significant bit first. The left field always comes before the right field, and that order cannot be swapped. A static ratio input selects a master clock of 256 or 384 times the sample rate. A 2-bit mode input selects one of four data positions inside each 32-bit field. A polarity input selects which bit-clock edge launches the data.

Sample pairs arrive through a ready/valid handshake. The block accepts a pair only near the end of the right field, holds it, and sends it during the following frame. If no pair arrives, the held pair is sent again. Internally, a divider creates a one-cycle `tick` at every launch edge. The frame sequencer walks the states `FR_LEFT` and `FR_RIGHT`; it moves to the other state on the tick that ends slot 31. The sample holder walks `HS_WAIT` and `HS_FULL`: it moves `HS_WAIT -> HS_FULL` when a pair is accepted, and `HS_FULL -> HS_WAIT` once the acceptance window closes. The word shifter walks `SH_QUIET` and `SH_SHIFT`: it moves `SH_QUIET -> SH_SHIFT` on the tick that loads a word, and `SH_SHIFT -> SH_QUIET` on the tick after the last bit.

Top module: `audio_ser_tx`

## Requirements
- R1: The bit clock period is 4 master-clock cycles when `ratio_384`=0 and 6 when `ratio_384`=1. It is high for exactly half of each period.
- R2: With `launch_fall`=1, `sdata`, `lrck` and `wclk` change on the falling bit-clock edge and are sampled on the rising edge. With `launch_fall`=0 the roles of the two edges are swapped.
- R3: A frame is 64 bit-clock slots. `lrck` is high for slots 0-31 (the left field) and low for slots 32-63 (the right field). `lrck` changes only on a launch edge.
- R4: Data is two's complement, MSB first. Mode 2'b01 (left-justified): field bits 0-15 carry the word and `wclk` is high for those bits. All other bits of the field are 0.
- R5: Mode 2'b00 (I2S-style): field bits 1-16 carry the word and `wclk` is high for those bits. All other bits are 0.
- R6: Mode 2'b11 (right-justified): field bits 16-31 carry the word and `wclk` is high for bits 16-31. All other bits are 0.
- R7: Mode 2'b10 (right-justified plus one): `wclk` is high only in field bit 16. Bits 17-31 carry word bits 15..1, and the LSB goes out in bit 0 of the following field.
- R8: `s_ready` is high only during slots 56-62 of a frame, and for at most one accepted pair per frame. A pair accepted there is sent in the next frame. A pair presented outside the window is not taken.
- R9: If no pair is accepted during a frame's window, the next frame repeats the previously held pair (zero after reset).
- R10: A synchronous active-low reset drives `bclk`, `lrck`, `wclk`, `sdata` and `s_ready` low and clears the held pair. The first clock edge after reset is released starts slot 0 of a left field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 or 384 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_384 | input | 1 | 1: master clock is 384x the sample rate (divide by 6); 0: 256x (divide by 4) |
| launch_fall | input | 1 | 1: launch on the falling bit-clock edge; 0: launch on the rising edge |
| mode | input | 2 | Data position: 00 I2S-style, 01 left, 10 right plus one, 11 right |
| s_valid | input | 1 | A sample pair is offered |
| s_ready | output | 1 | The block takes the offered pair on this clock |
| s_left | input | 16 | Left sample, two's complement |
| s_right | input | 16 | Right sample, two's complement |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Frame clock, high for the left field |
| wclk | output | 1 | Word-framing strobe |
| sdata | output | 1 | Serial data |

## Verification
In right-justified-plus-one mode, the bench checks bit 0 of each field against the LSB of the word from the previous field, including the previous frame's right word. A design that loaded the new word before the old LSB left, or that cleared the shifter at the field boundary, would send the wrong bit there. The bench runs every mode under both launch polarities and both clock ratios, sampling only on the sampling edge. A design that launched on the wrong edge, or that miscounted its divider, would shift every captured bit or change the frame length. Frames sent without a handshake are compared with the earlier pair. A pair held on the valid line from well before the window must be replaced by the data present when the window opens. This exposes a design that latches early data or accepts twice in one frame.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
    typedef enum logic [1:0] {
        MD_I2S = 2'b00,
        MD_LJ  = 2'b01,
        MD_RJ1 = 2'b10,
        MD_RJ  = 2'b11
    } aud_mode_e;
endpackage

// File: rtl/aud_bclk_div.sv
module aud_bclk_div #(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ratio_hi,
    input  logic launch_fall,
    output logic tick,
    output logic bclk
);
    localparam int CW = $clog2(DIV_HI);

    logic [CW-1:0] div_q, div_d, last, half;

    always_comb begin
        last  = ratio_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
        half  = ratio_hi ? CW'(DIV_HI / 2) : CW'(DIV_LO / 2);
        tick  = (div_q >= last);
        div_d = tick ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= last;
            bclk  <= 1'b0;
        end else begin
            div_q <= div_d;
            bclk  <= (div_d >= half) ^ ~launch_fall;
        end
    end

    AST_LAUNCH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (bclk == !$past(launch_fall)));   // R2
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);   // R1
endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq #(
    parameter int FIELD_W = 32,
    parameter int WIN     = 8,
    localparam int PW     = $clog2(FIELD_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic          nxt_left,
    output logic [PW-1:0] nxt_pos,
    output logic          win,
    output logic          lrck
);
    typedef enum logic {FR_LEFT, FR_RIGHT} fr_e;

    fr_e           fr_q, fr_d;
    logic [PW-1:0] pos_q;
    logic          field_end;

    always_comb begin
        field_end = (pos_q == PW'(FIELD_W - 1));
        nxt_pos   = field_end ? '0 : pos_q + 1'b1;
        fr_d      = fr_q;
        unique case (fr_q)
            FR_LEFT:  if (tick && field_end) fr_d = FR_RIGHT;
            FR_RIGHT: if (tick && field_end) fr_d = FR_LEFT;
        endcase
        nxt_left = (fr_d == FR_LEFT);
        win      = (fr_q == FR_RIGHT) && (pos_q >= PW'(FIELD_W - WIN)) && !field_end;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q  <= FR_RIGHT;
            pos_q <= PW'(FIELD_W - 1);
        end else if (tick) begin
            fr_q  <= fr_d;
            pos_q <= nxt_pos;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)    lrck <= 1'b0;
        else if (tick) lrck <= nxt_left;
    end

    AST_LEFT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fr_q == FR_RIGHT && field_end) |=> lrck);   // R3
    AST_LRCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lrck));   // R3
    AST_WIN_IN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> !lrck);   // R8
endmodule

// File: rtl/aud_sample_hold.sv
module aud_sample_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_left,
    input  logic [WORD_W-1:0] s_right,
    output logic [WORD_W-1:0] hold_l,
    output logic [WORD_W-1:0] hold_r
);
    typedef enum logic {HS_WAIT, HS_FULL} hs_e;

    hs_e  hs_q, hs_d;
    logic take;

    always_comb begin
        s_ready = win && (hs_q == HS_WAIT);
        take    = s_valid && s_ready;
        hs_d    = hs_q;
        unique case (hs_q)
            HS_WAIT: if (take) hs_d = HS_FULL;
            HS_FULL: if (!win) hs_d = HS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= HS_WAIT;
        else        hs_q <= hs_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (take) begin
            hold_l <= s_left;
            hold_r <= s_right;
        end
    end

    AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> win);   // R8
    AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);   // R8
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> ($stable(hold_l) && $stable(hold_r)));   // R9
endmodule

// File: rtl/aud_word_shift.sv
module aud_word_shift
    import aud_tx_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int FIELD_W = 32,
    localparam int PW     = $clog2(FIELD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        mode,
    input  logic              nxt_left,
    input  logic [PW-1:0]     nxt_pos,
    input  logic [WORD_W-1:0] hold_l,
    input  logic [WORD_W-1:0] hold_r,
    output logic              sdata,
    output logic              wclk
);
    localparam int CW = $clog2(WORD_W + 1);
    localparam int RJ_START = FIELD_W - WORD_W;

    typedef enum logic {SH_QUIET, SH_SHIFT} sh_e;

    aud_mode_e         md;
    sh_e               sh_q, sh_d;
    logic [WORD_W-1:0] sr_q, word;
    logic [CW-1:0]     cnt_q;
    logic [PW-1:0]     msb_pos;
    logic              load, wclk_d;

    always_comb begin
        md = aud_mode_e'(mode);
        unique case (md)
            MD_LJ: begin
                msb_pos = '0;
                wclk_d  = (nxt_pos < PW'(WORD_W));
            end
            MD_I2S: begin
                msb_pos = PW'(1);
                wclk_d  = (nxt_pos >= PW'(1)) && (nxt_pos <= PW'(WORD_W));
            end
            MD_RJ: begin
                msb_pos = PW'(RJ_START);
                wclk_d  = (nxt_pos >= PW'(RJ_START));
            end
            MD_RJ1: begin
                msb_pos = PW'(RJ_START + 1);
                wclk_d  = (nxt_pos == PW'(RJ_START));
            end
        endcase
        load = tick && (nxt_pos == msb_pos);
        word = nxt_left ? hold_l : hold_r;
        sh_d = sh_q;
        unique case (sh_q)
            SH_QUIET: if (load) sh_d = SH_SHIFT;
            SH_SHIFT: if (!load && tick && cnt_q == '0) sh_d = SH_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= SH_QUIET;
        else        sh_q <= sh_d;
    end

    // outputs and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
            sdata <= 1'b0;
            wclk  <= 1'b0;
        end else if (tick) begin
            wclk <= wclk_d;
            if (load) begin
                sdata <= word[WORD_W-1];
                sr_q  <= word << 1;
                cnt_q <= CW'(WORD_W - 1);
            end else if (sh_q == SH_SHIFT && cnt_q != '0) begin
                sdata <= sr_q[WORD_W-1];
                sr_q  <= sr_q << 1;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                sdata <= 1'b0;
            end
        end
    end

    AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q == SH_QUIET) |-> !sdata);   // R4
    AST_DATA_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(sdata) && $stable(wclk)));   // R2
    AST_PULSE_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (md == MD_RJ1 && wclk && tick) |=> !wclk);   // R7
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
    parameter int WORD_W  = 16,
    parameter int FIELD_W = 32,
    parameter int WIN     = 8,
    parameter int DIV_LO  = 4,
    parameter int DIV_HI  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ratio_384,
    input  logic              launch_fall,
    input  logic [1:0]        mode,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_left,
    input  logic [WORD_W-1:0] s_right,
    output logic              bclk,
    output logic              lrck,
    output logic              wclk,
    output logic              sdata
);
    localparam int PW = $clog2(FIELD_W);

    logic              tick, nxt_left, win;
    logic [PW-1:0]     nxt_pos;
    logic [WORD_W-1:0] hold_l, hold_r;

    aud_bclk_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
        .clk(clk), .rst_n(rst_n), .ratio_hi(ratio_384),
        .launch_fall(launch_fall), .tick(tick), .bclk(bclk)
    );

    aud_frame_seq #(.FIELD_W(FIELD_W), .WIN(WIN)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nxt_left(nxt_left),
        .nxt_pos(nxt_pos), .win(win), .lrck(lrck)
    );

    aud_sample_hold #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .win(win), .s_valid(s_valid),
        .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
        .hold_l(hold_l), .hold_r(hold_r)
    );

    aud_word_shift #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .nxt_left(nxt_left), .nxt_pos(nxt_pos), .hold_l(hold_l),
        .hold_r(hold_r), .sdata(sdata), .wclk(wclk)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!bclk && !lrck && !wclk && !sdata));   // R10
endmodule

// File: tb/tb_audio_ser_tx.sv
`timescale 1ns/1ps
module tb_audio_ser_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ratio_384 = 1'b0, launch_fall = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [15:0] s_left = '0, s_right = '0;
    logic        bclk, lrck, wclk, sdata;

    always #2.5 clk = ~clk;

    audio_ser_tx dut (
        .clk(clk), .rst_n(rst_n), .ratio_384(ratio_384), .launch_fall(launch_fall),
        .mode(mode), .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left),
        .s_right(s_right), .bclk(bclk), .lrck(lrck), .wclk(wclk), .sdata(sdata)
    );

    typedef struct packed {
        logic        r384;
        logic        lf;
        logic [1:0]  md;
        logic [15:0] al, ar, bl, br;
    } vec_t;

    localparam vec_t TBL [0:7] = '{
        '{1'b0, 1'b1, 2'b01, 16'h8001, 16'h7FFE, 16'hA5C3, 16'h1234},
        '{1'b1, 1'b0, 2'b01, 16'hC0DE, 16'h0F0F, 16'h5A5A, 16'h8000},
        '{1'b0, 1'b0, 2'b00, 16'h1357, 16'hFFFF, 16'h0001, 16'hECA8},
        '{1'b1, 1'b1, 2'b00, 16'h8421, 16'h2468, 16'h7FFF, 16'h8000},
        '{1'b0, 1'b1, 2'b11, 16'h9ABC, 16'h0123, 16'hF00F, 16'h3C3C},
        '{1'b1, 1'b0, 2'b11, 16'h4321, 16'hACE1, 16'h0000, 16'hFFFE},
        '{1'b0, 1'b1, 2'b10, 16'hB00B, 16'h1FE1, 16'h6DB6, 16'h9249},
        '{1'b1, 1'b0, 2'b10, 16'h0FF0, 16'hC3A5, 16'h8001, 16'h7FFF}
    };

    int n_chk = 0, n_bad = 0;

    // capture state, sampled on negedges only
    logic [63:0] cap_d [4];
    logic [63:0] cap_w [4];
    logic [63:0] cap_l [4];
    int   nfr, fidx, cyc, last_edge, per_f1, cyc_f1, hi_f1, rdy_f1;
    logic started, prev_lr, prev_b;

    always @(negedge clk) begin
        if (!rst_n) begin
            nfr = 0; fidx = 0; cyc = 0; last_edge = 0; per_f1 = 0;
            cyc_f1 = 0; hi_f1 = 0; rdy_f1 = 0;
            started = 1'b0; prev_lr = 1'b0; prev_b = 1'b0;
        end else begin
            cyc++;
            if (nfr == 1) begin
                cyc_f1++;
                if (bclk) hi_f1++;
                if (s_ready) rdy_f1++;
            end
            if (bclk != prev_b && bclk == launch_fall) begin
                if (nfr == 1) per_f1 = cyc - last_edge;
                last_edge = cyc;
                if (lrck && !prev_lr) begin
                    fidx = 0;
                    started = 1'b1;
                end else begin
                    fidx++;
                end
                if (started && nfr < 4 && fidx < 64) begin
                    cap_d[nfr][fidx] = sdata;
                    cap_w[nfr][fidx] = wclk;
                    cap_l[nfr][fidx] = lrck;
                    if (fidx == 63) nfr++;
                end
                prev_lr = lrck;
            end
            prev_b = bclk;
        end
    end

    function automatic logic exp_d(input logic [1:0] md, input int idx,
                                   input logic [15:0] l, input logic [15:0] r,
                                   input logic [15:0] pr);
        int p;
        logic [15:0] w;
        p = idx % 32;
        w = (idx >= 32) ? r : l;
        case (md)
            2'b01:   exp_d = (p < 16) ? w[15-p] : 1'b0;
            2'b00:   exp_d = (p >= 1 && p <= 16) ? w[16-p] : 1'b0;
            2'b11:   exp_d = (p >= 16) ? w[31-p] : 1'b0;
            default: exp_d = (p >= 17) ? w[32-p] :
                             (p == 0) ? ((idx >= 32) ? l[0] : pr[0]) : 1'b0;
        endcase
    endfunction

    function automatic logic exp_w(input logic [1:0] md, input int idx);
        int p;
        p = idx % 32;
        case (md)
            2'b01:   exp_w = (p < 16);
            2'b00:   exp_w = (p >= 1 && p <= 16);
            2'b11:   exp_w = (p >= 16);
            default: exp_w = (p == 16);
        endcase
    endfunction

    function automatic logic [63:0] frame_d(input logic [1:0] md, input logic [15:0] l,
                                            input logic [15:0] r, input logic [15:0] pr);
        logic [63:0] v;
        for (int k = 0; k < 64; k++) v[k] = exp_d(md, k, l, r, pr);
        return v;
    endfunction

    function automatic logic [63:0] frame_w(input logic [1:0] md);
        logic [63:0] v;
        for (int k = 0; k < 64; k++) v[k] = exp_w(md, k);
        return v;
    endfunction

    function automatic string mode_req(input logic [1:0] md);
        case (md)
            2'b01:   return "R4";
            2'b00:   return "R5";
            2'b11:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic offer(input logic [15:0] l, input logic [15:0] r);
        @(posedge clk); #1;
        s_left = l; s_right = r; s_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (s_ready) break;
        end
        @(posedge clk); #1;
        s_valid = 1'b0;
    endtask

    task automatic do_reset(input logic r384, input logic lf, input logic [1:0] md);
        @(posedge clk); #1;
        rst_n = 1'b0; s_valid = 1'b0;
        ratio_384 = r384; launch_fall = lf; mode = md;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: all outputs low while reset is held
        chk("R10 reset state", {59'd0, bclk, lrck, wclk, sdata, s_ready}, 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R10: left field starts on the first edge after release
        chk("R10 left first", {63'd0, lrck}, 64'd1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            int   dv;
            v  = TBL[i];
            dv = v.r384 ? 6 : 4;
            do_reset(v.r384, v.lf, v.md);
            offer(v.al, v.ar);
            wait (nfr >= 2);
            offer(v.bl, v.br);
            wait (nfr >= 4);
            // frame 1: pair A, accepted in frame 0 (R8); polarity (R2); mode position
            chk({"R2 R8 ", mode_req(v.md), " data f1"}, cap_d[1], frame_d(v.md, v.al, v.ar, 16'h0000));
            // frame 2: no handshake, pair A repeated (R9)
            chk({"R2 R9 ", mode_req(v.md), " data f2"}, cap_d[2], frame_d(v.md, v.al, v.ar, v.ar));
            // frame 3: pair B
            chk({"R2 R8 ", mode_req(v.md), " data f3"}, cap_d[3], frame_d(v.md, v.bl, v.br, v.ar));
            for (int f = 1; f < 4; f++)
                chk({mode_req(v.md), " wclk"}, cap_w[f], frame_w(v.md));
            chk("R3 lrck pattern", cap_l[1], {32'h0000_0000, 32'hFFFF_FFFF});
            chk("R3 frame length", 64'(cyc_f1), 64'(64 * dv));
            chk("R1 bclk period", 64'(per_f1), 64'(dv));
            chk("R1 bclk high time", 64'(hi_f1), 64'(32 * dv));
            chk("R8 ready window", 64'(rdy_f1), 64'(7 * dv));
        end

        // directed: a pair offered before the window is not latched (R8)
        do_reset(1'b0, 1'b1, 2'b01);
        @(posedge clk); #1;
        s_left = 16'h1111; s_right = 16'h2222; s_valid = 1'b1;
        wait (started && fidx >= 40);
        @(posedge clk); #1;
        chk("R8 no early ready", {63'd0, s_ready}, 64'd0);
        s_left = 16'hBEEF; s_right = 16'h0DD0;
        forever begin
            @(negedge clk);
            if (s_ready) break;
        end
        @(posedge clk); #1;
        s_valid = 1'b0;
        wait (nfr >= 2);
        chk("R8 R4 late data taken", cap_d[1], frame_d(2'b01, 16'hBEEF, 16'h0DD0, 16'h0000));

        // directed: reset in mid-frame clears the held pair (R10)
        do_reset(1'b1, 1'b1, 2'b11);
        wait (nfr >= 2);
        chk("R10 R9 held pair cleared", cap_d[1], 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule